// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This block handles in-band software flow control next to a UART core. On the receive path it watches every received character and compares it with four programmable flow characters: two resume characters (XON1, XON2) and two pause characters (XOFF1, XOFF2). A pause match stops the local transmitter and a resume match releases it. Matched flow characters are recorded in a sticky status nibble and are kept out of the receive FIFO. All other characters go on to the FIFO one cycle later.

On the transmit path the block watches the receive FIFO fill level. When the level climbs to the halt threshold, the block asks the transmitter to insert a pause sequence. When the level falls back to the resume threshold, it asks for a resume sequence. Both thresholds are given in units of eight words. A 4-bit mode field sets, for each direction separately, which character set takes part: the first set, the second set, both sets, or neither. A master enable turns the whole function on or off.

Top module: `swflow_ctrl`

## Requirements
- R1: After reset, tx_allow is 1, ins_req is 0, fwd_vld is 0 and spc_flags is 0000.
- R2: mode[1:0] selects the receive match set: 01 matches XON2/XOFF2, 10 matches XON1/XOFF1, 11 matches all four, and 00 matches none. A matched pause character drives tx_allow to 0 one cycle after the character. A matched resume character drives it back to 1 one cycle after the character.
- R3: spc_flags bit 0 stands for XON1, bit 1 for XON2, bit 2 for XOFF1 and bit 3 for XOFF2. A bit sets one cycle after its character is matched, and it stays set.
- R4: A flag_clr pulse clears spc_flags in the next cycle. A match in the same cycle as the clear still sets its bit.
- R5: A matched flow character is not forwarded. Every other received character appears on fwd_data with fwd_vld exactly one cycle after it arrives.
- R6: With sw_en at 0, no character is matched, every character is forwarded, tx_allow stays 1, spc_flags does not change and ins_req stays 0.
- R7: When rx_lvl becomes at least 8 times the halt nibble (thr_cfg[3:0]) while not halted, the block issues one pause sequence, starting the cycle after. It issues no further pause sequence while the level stays high.
- R8: Once halted, when rx_lvl falls to 8 times the resume nibble (thr_cfg[7:4]) or below, the block issues one resume sequence, starting the cycle after.
- R9: mode[3:2] selects what the transmit side inserts: 01 sends XOFF2 and XON2, 10 sends XOFF1 and XON1, 11 sends XOFF1 followed by XOFF2 and XON1 followed by XON2, and 00 inserts nothing.
- R10: ins_req stays high with ins_data unchanged until ins_ack. After the last byte of a sequence is acknowledged, ins_req falls in the next cycle. After an earlier byte is acknowledged, the next byte is presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_en | input | 1 | Master enable for software flow control |
| mode | input | 4 | [1:0] receive match set, [3:2] transmit insert set |
| chr_xon1 | input | DATA_W | First resume character |
| chr_xon2 | input | DATA_W | Second resume character |
| chr_xoff1 | input | DATA_W | First pause character |
| chr_xoff2 | input | DATA_W | Second pause character |
| thr_cfg | input | 2*THR_W | Low nibble halt level, high nibble resume level, in units of 8 words |
| rx_vld | input | 1 | Received character valid |
| rx_data | input | DATA_W | Received character |
| rx_lvl | input | LVL_W | Receive FIFO fill level in words |
| ins_ack | input | 1 | Transmitter accepted the inserted byte |
| flag_clr | input | 1 | Clears the detect flags |
| tx_allow | output | 1 | Transmit enable gate |
| ins_req | output | 1 | Request to insert a flow character |
| ins_data | output | DATA_W | Flow character to insert |
| fwd_vld | output | 1 | Forwarded character valid, toward the receive FIFO |
| fwd_data | output | DATA_W | Forwarded character |
| spc_flags | output | 4 | Sticky flow-character detect flags |

## Verification
Each receive-side result (forwarding, the tx_allow change and the flag set) is due one cycle after the character, and the flag clear is due one cycle after its pulse. An insertion request is due one cycle after the FIFO level crosses a threshold, and the following byte is due one cycle after the acknowledge. The bench drives inputs on the falling edge and samples on the next falling edge, so each result is seen exactly one register stage after its cause. A monitor compares forwarded bytes and inserted bytes, in order, against queues that the driver fills before each stimulus, so an extra or repeated sequence shows up as an unexpected item.

// File: rtl/swflow_pkg.sv
package swflow_pkg;
   // set selector encoding, shared by both directions
   typedef enum logic [1:0] {
      SEL_NONE = 2'b00,
      SEL_SET2 = 2'b01,
      SEL_SET1 = 2'b10,
      SEL_BOTH = 2'b11
   } set_sel_e;

   // detect flag positions (a neighbour decodes these)
   localparam int FLG_XON1  = 0;
   localparam int FLG_XON2  = 1;
   localparam int FLG_XOFF1 = 2;
   localparam int FLG_XOFF2 = 3;
   localparam int FLG_N     = 4;

   function automatic logic set1_on(input logic [1:0] sel);
      return sel[1];
   endfunction

   function automatic logic set2_on(input logic [1:0] sel);
      return sel[0];
   endfunction
endpackage

// File: rtl/swflow_rx_match.sv
module swflow_rx_match
   import swflow_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [1:0]        sel,
   input  logic              rx_vld,
   input  logic [DATA_W-1:0] rx_data,
   input  logic [DATA_W-1:0] chr [FLG_N],
   output logic [FLG_N-1:0]  hit,
   output logic              paused,
   output logic              fwd_vld,
   output logic [DATA_W-1:0] fwd_data
);
   // even indices belong to set 1, odd indices to set 2
   for (genvar i = 0; i < FLG_N; i++) begin : g_cmp
      logic set_en;
      if (i % 2 == 0) begin : g_s1
         assign set_en = set1_on(sel);
      end else begin : g_s2
         assign set_en = set2_on(sel);
      end
      assign hit[i] = active & rx_vld & set_en & (rx_data == chr[i]);
   end

   logic pause_hit, resume_hit;
   assign pause_hit  = hit[FLG_XOFF1] | hit[FLG_XOFF2];
   assign resume_hit = hit[FLG_XON1]  | hit[FLG_XON2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         paused   <= 1'b0;
         fwd_vld  <= 1'b0;
         fwd_data <= '0;
      end else begin
         if (!active)         paused <= 1'b0;
         else if (pause_hit)  paused <= 1'b1;
         else if (resume_hit) paused <= 1'b0;
         fwd_vld  <= rx_vld & ~(|hit);
         fwd_data <= rx_data;
      end
   end
endmodule

// File: rtl/swflow_flags.sv
module swflow_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr,
   output logic [N-1:0] flags
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (clr ? '0 : flags) | set;
   end
endmodule

// File: rtl/swflow_tx_inject.sv
module swflow_tx_inject
   import swflow_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int LVL_W     = 8,
   parameter int THR_W     = 4,
   parameter int UNIT_LOG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [1:0]        sel,
   input  logic [THR_W-1:0]  halt_thr,
   input  logic [THR_W-1:0]  res_thr,
   input  logic [LVL_W-1:0]  lvl,
   input  logic [DATA_W-1:0] chr [FLG_N],
   input  logic              ins_ack,
   output logic              ins_req,
   output logic [DATA_W-1:0] ins_data
);
   localparam int SCL_W = THR_W + UNIT_LOG2;
   localparam int CMP_W = (SCL_W > LVL_W) ? SCL_W : LVL_W;

   logic [CMP_W-1:0] lvl_x, halt_x, res_x;
   assign lvl_x  = CMP_W'(lvl);
   assign halt_x = CMP_W'({halt_thr, {UNIT_LOG2{1'b0}}});
   assign res_x  = CMP_W'({res_thr,  {UNIT_LOG2{1'b0}}});

   logic              halted_q, req_q, more_q;
   logic [DATA_W-1:0] byte_a, byte_b;

   assign ins_req  = req_q;
   assign ins_data = byte_a;

   // pick first and second byte of a sequence; pause=1 selects XOFF
   function automatic logic [2*DATA_W:0] pick(input logic pause,
                                              input logic [1:0] s,
                                              input logic [DATA_W-1:0] c [FLG_N]);
      logic [DATA_W-1:0] one, two;
      one = pause ? c[FLG_XOFF1] : c[FLG_XON1];
      two = pause ? c[FLG_XOFF2] : c[FLG_XON2];
      case (s)
         SEL_SET2: return {1'b0, two, two};
         SEL_SET1: return {1'b0, one, one};
         default:  return {1'b1, one, two};
      endcase
   endfunction

   logic              go_halt, go_res;
   logic [2*DATA_W:0] seq;
   assign go_halt = !req_q && !halted_q && (lvl_x >= halt_x);
   assign go_res  = !req_q &&  halted_q && (lvl_x <= res_x);
   assign seq     = pick(go_halt, sel, chr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         req_q    <= 1'b0;
         more_q   <= 1'b0;
         byte_a   <= '0;
         byte_b   <= '0;
      end else if (!active) begin
         halted_q <= 1'b0;
         req_q    <= 1'b0;
         more_q   <= 1'b0;
      end else if (req_q) begin
         if (ins_ack) begin
            if (more_q) begin
               byte_a <= byte_b;
               more_q <= 1'b0;
            end else begin
               req_q <= 1'b0;
            end
         end
      end else if (go_halt || go_res) begin
         halted_q <= go_halt;
         req_q    <= 1'b1;
         more_q   <= seq[2*DATA_W];
         byte_a   <= seq[2*DATA_W-1:DATA_W];
         byte_b   <= seq[DATA_W-1:0];
      end
   end
endmodule

// File: rtl/swflow_ctrl.sv
module swflow_ctrl
   import swflow_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int LVL_W     = 8,
   parameter int THR_W     = 4,
   parameter int UNIT_LOG2 = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sw_en,
   input  logic [3:0]           mode,
   input  logic [DATA_W-1:0]    chr_xon1,
   input  logic [DATA_W-1:0]    chr_xon2,
   input  logic [DATA_W-1:0]    chr_xoff1,
   input  logic [DATA_W-1:0]    chr_xoff2,
   input  logic [2*THR_W-1:0]   thr_cfg,
   input  logic                 rx_vld,
   input  logic [DATA_W-1:0]    rx_data,
   input  logic [LVL_W-1:0]     rx_lvl,
   input  logic                 ins_ack,
   input  logic                 flag_clr,
   output logic                 tx_allow,
   output logic                 ins_req,
   output logic [DATA_W-1:0]    ins_data,
   output logic                 fwd_vld,
   output logic [DATA_W-1:0]    fwd_data,
   output logic [FLG_N-1:0]     spc_flags
);
   if (DATA_W < 5 || DATA_W > 9) begin : g_bad_data_w
      $error("swflow_ctrl: DATA_W must lie in 5..9");
   end
   if (THR_W < 1 || LVL_W < 1) begin : g_bad_lvl_w
      $error("swflow_ctrl: THR_W and LVL_W must be positive");
   end

   logic [DATA_W-1:0] chr [FLG_N];
   assign chr[FLG_XON1]  = chr_xon1;
   assign chr[FLG_XON2]  = chr_xon2;
   assign chr[FLG_XOFF1] = chr_xoff1;
   assign chr[FLG_XOFF2] = chr_xoff2;

   logic rx_act, tx_act, paused;
   logic [FLG_N-1:0] hit;
   assign rx_act = sw_en & (|mode[1:0]);
   assign tx_act = sw_en & (|mode[3:2]);

   swflow_rx_match #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .active(rx_act), .sel(mode[1:0]),
      .rx_vld(rx_vld), .rx_data(rx_data), .chr(chr), .hit(hit),
      .paused(paused), .fwd_vld(fwd_vld), .fwd_data(fwd_data)
   );

   swflow_flags #(.N(FLG_N)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(hit), .clr(flag_clr), .flags(spc_flags)
   );

   swflow_tx_inject #(
      .DATA_W(DATA_W), .LVL_W(LVL_W), .THR_W(THR_W), .UNIT_LOG2(UNIT_LOG2)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .active(tx_act), .sel(mode[3:2]),
      .halt_thr(thr_cfg[THR_W-1:0]), .res_thr(thr_cfg[2*THR_W-1:THR_W]),
      .lvl(rx_lvl), .chr(chr), .ins_ack(ins_ack),
      .ins_req(ins_req), .ins_data(ins_data)
   );

   assign tx_allow = ~(paused & rx_act);
endmodule

// File: rtl/swflow_chk.sv
module swflow_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_en,
   input logic [3:0]        mode,
   input logic              rx_vld,
   input logic              flag_clr,
   input logic              ins_ack,
   input logic              ins_req,
   input logic [DATA_W-1:0] ins_data,
   input logic              fwd_vld,
   input logic [3:0]        spc_flags,
   input logic              tx_allow
);
   // R10: request and byte hold until acknowledged
   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && !ins_ack && sw_en && mode[3:2] != 2'b00) |=> (ins_req && $stable(ins_data)));

   // R5: a forwarded byte always follows a received one
   assert_fwd_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_vld |-> $past(rx_vld));

   // R3: flags never drop without a clear
   assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_clr |=> ((spc_flags & $past(spc_flags)) == $past(spc_flags)));

   // R4: clear with no incoming character empties the flags
   assert_flags_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !rx_vld) |=> (spc_flags == 4'b0000));

   // R2: transmitter pauses only because of a received character
   assert_pause_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_allow) |-> $past(rx_vld));

   // R6: disabled block requests nothing
   assert_idle_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_en |=> !ins_req);
endmodule

bind swflow_ctrl swflow_chk #(.DATA_W(DATA_W)) u_swflow_chk (
   .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .mode(mode), .rx_vld(rx_vld),
   .flag_clr(flag_clr), .ins_ack(ins_ack), .ins_req(ins_req),
   .ins_data(ins_data), .fwd_vld(fwd_vld), .spc_flags(spc_flags),
   .tx_allow(tx_allow)
);

// File: tb/tb_swflow_ctrl.sv
module tb_swflow_ctrl;
   localparam logic [7:0] XON1 = 8'h11, XOFF1 = 8'h13, XON2 = 8'h91, XOFF2 = 8'h93;

   logic       clk = 0, rst_n = 0, sw_en = 0, rx_vld = 0, ins_ack = 0, flag_clr = 0;
   logic [3:0] mode = 4'b0000;
   logic [7:0] thr_cfg = 8'h14;     // halt 4*8=32, resume 1*8=8
   logic [7:0] rx_data = 8'h00, rx_lvl = 8'h00;
   logic       tx_allow, ins_req, fwd_vld;
   logic [7:0] ins_data, fwd_data;
   logic [3:0] spc_flags;

   int  checks = 0, errors = 0;
   bit  done = 0, stall = 0;
   logic [7:0] fwd_q[$], ins_q[$];

   always #2.5 clk = ~clk;   // 200 MHz

   swflow_ctrl dut (
      .clk(clk), .rst_n(rst_n), .sw_en(sw_en), .mode(mode),
      .chr_xon1(XON1), .chr_xon2(XON2), .chr_xoff1(XOFF1), .chr_xoff2(XOFF2),
      .thr_cfg(thr_cfg), .rx_vld(rx_vld), .rx_data(rx_data), .rx_lvl(rx_lvl),
      .ins_ack(ins_ack), .flag_clr(flag_clr), .tx_allow(tx_allow),
      .ins_req(ins_req), .ins_data(ins_data), .fwd_vld(fwd_vld),
      .fwd_data(fwd_data), .spc_flags(spc_flags)
   );

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", what, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: push expectation, then present one character for one cycle
   task automatic send(input logic [7:0] d, input bit fwd);
      if (fwd) fwd_q.push_back(d);
      rx_data = d; rx_vld = 1;
      @(negedge clk);
      rx_vld = 0;
   endtask

   task automatic pulse_clr();
      flag_clr = 1; @(negedge clk); flag_clr = 0;
      chk(spc_flags == 4'b0000, "R4 flags after clear", spc_flags, 0);
   endtask

   task automatic level(input logic [7:0] l, input bit expect_req, input string tag);
      rx_lvl = l;
      @(negedge clk);
      chk(ins_req == expect_req, tag, ins_req, expect_req);
      idle(6);
      chk(ins_q.size() == 0, {tag, " all bytes inserted"}, ins_q.size(), 0);
   endtask

   // monitor: compares forwarded and inserted bytes against the queues
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (fwd_vld) begin
            if (fwd_q.size() == 0) chk(0, "R5 unexpected forwarded byte", fwd_data, 0);
            else begin
               logic [7:0] e;
               e = fwd_q.pop_front();
               chk(fwd_data == e, "R5 forwarded byte", fwd_data, e);
            end
         end
         ins_ack = 0;
         if (ins_req && !stall) begin
            if (ins_q.size() == 0) chk(0, "R7 unexpected inserted byte", ins_data, 0);
            else begin
               logic [7:0] e;
               e = ins_q.pop_front();
               chk(ins_data == e, "R9 inserted byte", ins_data, e);
            end
            ins_ack = 1;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog act=1 exp=0");
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1;
      @(negedge clk);
      chk(tx_allow == 1, "R1 tx_allow reset", tx_allow, 1);
      chk(ins_req == 0, "R1 ins_req reset", ins_req, 0);
      chk(fwd_vld == 0, "R1 fwd_vld reset", fwd_vld, 0);
      chk(spc_flags == 0, "R1 flags reset", spc_flags, 0);

      // receive side, both sets
      sw_en = 1; mode = 4'b0011;
      send(8'h41, 1);
      chk(tx_allow == 1, "R5 plain char keeps tx", tx_allow, 1);
      send(XOFF1, 0);
      chk(tx_allow == 0, "R2 XOFF1 pauses", tx_allow, 0);
      chk(spc_flags == 4'b0100, "R3 XOFF1 flag", spc_flags, 4'b0100);
      send(XON2, 0);
      chk(tx_allow == 1, "R2 XON2 resumes", tx_allow, 1);
      chk(spc_flags == 4'b0110, "R3 flags sticky", spc_flags, 4'b0110);
      pulse_clr();
      flag_clr = 1;
      send(XOFF2, 0);
      flag_clr = 0;
      chk(spc_flags == 4'b1000, "R4 set wins over clear", spc_flags, 4'b1000);
      chk(tx_allow == 0, "R2 XOFF2 pauses", tx_allow, 0);
      send(XON1, 0);
      chk(tx_allow == 1, "R2 XON1 resumes", tx_allow, 1);
      chk(spc_flags == 4'b1001, "R3 XON1 flag", spc_flags, 4'b1001);
      pulse_clr();

      // set 2 only
      mode = 4'b0001;
      send(XOFF1, 1);
      chk(tx_allow == 1, "R2 set2 ignores XOFF1", tx_allow, 1);
      chk(spc_flags == 0, "R3 set2 no XOFF1 flag", spc_flags, 0);
      send(XOFF2, 0);
      chk(tx_allow == 0, "R2 set2 XOFF2 pauses", tx_allow, 0);
      send(XON1, 1);
      chk(tx_allow == 0, "R2 set2 ignores XON1", tx_allow, 0);
      send(XON2, 0);
      chk(tx_allow == 1, "R2 set2 XON2 resumes", tx_allow, 1);
      chk(spc_flags == 4'b1010, "R3 set2 flags", spc_flags, 4'b1010);
      pulse_clr();

      // set 1 only
      mode = 4'b0010;
      send(XON2, 1);
      send(XOFF2, 1);
      chk(tx_allow == 1, "R2 set1 ignores XOFF2", tx_allow, 1);
      send(XOFF1, 0);
      chk(tx_allow == 0, "R2 set1 XOFF1 pauses", tx_allow, 0);
      send(XON1, 0);
      chk(tx_allow == 1, "R2 set1 XON1 resumes", tx_allow, 1);
      chk(spc_flags == 4'b0101, "R3 set1 flags", spc_flags, 4'b0101);
      pulse_clr();

      // receive mode 00
      mode = 4'b0000;
      send(XOFF1, 1);
      chk(tx_allow == 1, "R2 mode 00 no pause", tx_allow, 1);
      chk(spc_flags == 0, "R2 mode 00 no flag", spc_flags, 0);

      // disabled
      sw_en = 0; mode = 4'b0011;
      send(XOFF2, 1);
      chk(tx_allow == 1, "R6 disabled no pause", tx_allow, 1);
      chk(spc_flags == 0, "R6 disabled no flag", spc_flags, 0);
      idle(2);
      chk(fwd_q.size() == 0, "R5 all forwarded", fwd_q.size(), 0);

      // transmit side, set 1
      sw_en = 1; mode = 4'b1000;
      level(8'd31, 0, "R7 below halt no request");
      ins_q.push_back(XOFF1);
      level(8'd32, 1, "R7 halt request");
      level(8'd60, 0, "R7 no repeat while high");
      level(8'd9, 0, "R8 above resume no request");
      ins_q.push_back(XON1);
      level(8'd8, 1, "R8 resume request");

      // set 2
      mode = 4'b0100;
      ins_q.push_back(XOFF2);
      level(8'd40, 1, "R9 set2 halt");
      ins_q.push_back(XON2);
      level(8'd0, 1, "R9 set2 resume");

      // both sets
      mode = 4'b1100;
      ins_q.push_back(XOFF1); ins_q.push_back(XOFF2);
      level(8'd32, 1, "R9 both halt pair");
      ins_q.push_back(XON1); ins_q.push_back(XON2);
      level(8'd8, 1, "R9 both resume pair");

      // stalled acknowledge
      stall = 1;
      ins_q.push_back(XOFF1); ins_q.push_back(XOFF2);
      rx_lvl = 8'd33;
      idle(5);
      chk(ins_req == 1, "R10 request held", ins_req, 1);
      chk(ins_data == XOFF1, "R10 byte held", ins_data, XOFF1);
      stall = 0;
      idle(6);
      chk(ins_q.size() == 0, "R10 pair after stall", ins_q.size(), 0);
      ins_q.push_back(XON1); ins_q.push_back(XON2);
      level(8'd0, 1, "R10 resume pair");

      // transmit mode 00 and disabled
      mode = 4'b0000;
      level(8'd40, 0, "R9 mode 00 no request");
      sw_en = 0; mode = 4'b1000;
      level(8'd50, 0, "R6 disabled no request");
      rx_lvl = 0;
      idle(2);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule